// File: doc/BRIEF.md
# CSI-2 RAW Pixel Depacker with Per-Packet Format Detection

This block sits behind a CSI-2 receiver whose lanes have already been deskewed and merged, and whose packet headers and payload checksums have been checked upstream. It takes the payload bytes of each long packet, `LANES` bytes per beat, and turns them into a bus of `PPC` pixels per clock, `MAXW` bits per pixel. The first pixel of every packet is flagged as a line start and the last one as a line end.

The data type in each packet header selects the unpacking rule for that packet only. A sensor can therefore move between 10-, 12- and 14-bit modes from one line to the next with no rebuild. Packets with a type the build cannot handle are discarded, and a sticky flag reports them. The lane count, the output width in pixels and the largest pixel width are parameters. Lane count and pixels per clock must form one of four legal pairs: 2/2, 2/4, 4/4 or 4/8. Any other pair stops elaboration.

The source must follow three rules. Each header comes one cycle ahead of its first payload beat. The word count is a whole number of pixel groups. At least 16 idle cycles separate the last payload beat of one packet from the next header, which gives the previous line time to drain.

Top module: `csi_raw_depack`

## Requirements
- R1: Data type 0x2B is unpacked in groups of 5 bytes giving 4 pixels. Bytes 0 to 3 carry the upper 8 bits of pixels 0 to 3, and byte 4 carries the 2-bit remainders, pixel i in bits [2i+1:2i].
- R2: Data type 0x2C is unpacked in groups of 3 bytes giving 2 pixels. Bytes 0 and 1 carry the upper 8 bits, and byte 2 holds the low nibble of pixel 0 in bits [3:0] and of pixel 1 in bits [7:4].
- R3: Data type 0x2D is unpacked in groups of 7 bytes giving 4 pixels. Bytes 0 to 3 carry the upper 8 bits, and bytes 4 to 6 form a little-endian 24-bit word holding the 6-bit remainder of pixel i in bits [6i+5:6i].
- R4: The format is taken from each packet's header, so packets of different types that follow one another are each unpacked by their own rule.
- R5: Every output pixel is left-justified to `MAXW` bits, and the bits below the pixel's own width are zero.
- R6: Pixels leave in payload order, lane 0 first, with no loss and no duplication. `pix_keep` has a bit set for each occupied lane and is contiguous from lane 0. It is all ones on every beat except the line-end beat.
- R7: `line_start` is raised on the beat that carries a packet's first pixel, and `line_end` on the beat that carries its last pixel. Both are raised on the same beat when the packet holds no more than `PPC` pixels.
- R8: A header with any other type, or with a type wider than `MAXW`, produces no output beats. Its payload is discarded and `unsupported` is set. The flag stays set through later valid packets.
- R9: While reset is active and after it is released, `pix_valid`, `line_start`, `line_end` and `unsupported` are 0.
- R10: Payload bytes beyond the header's byte count, whether unused lanes of the last beat or beats with no open packet, have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Long-packet header present this cycle |
| hdr_dt | input | 6 | Header data type |
| hdr_wc | input | 16 | Header payload byte count |
| pl_valid | input | 1 | Payload beat present |
| pl_data | input | LANES*8 | Payload bytes, byte 0 in bits [7:0] |
| pix_valid | output | 1 | Output beat present |
| pix_data | output | PPC*MAXW | Pixels, lane 0 in the low bits |
| pix_keep | output | PPC | Occupied lanes of this beat |
| line_start | output | 1 | Beat carries the packet's first pixel |
| line_end | output | 1 | Beat carries the packet's last pixel |
| unsupported | output | 1 | Sticky: an unhandled packet type was seen |

## Verification
The line-start and line-end strobes can fall in the same cycle. This happens when a packet carries no more than one beat of pixels. The stimulus table includes a 2-pixel 12-bit packet and a 4-pixel 14-bit packet to force this case. Each beat's strobes are compared with per-pixel first and last marks that the bench computes when it builds each packet. The bench also counts the beats on which both strobes are raised and expects at least one.

// File: rtl/csid_pkg.sv
package csid_pkg;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_R10  = 2'd1,
    FMT_R12  = 2'd2,
    FMT_R14  = 2'd3
  } fmt_e;

  localparam logic [5:0] DT_RAW10 = 6'h2B;
  localparam logic [5:0] DT_RAW12 = 6'h2C;
  localparam logic [5:0] DT_RAW14 = 6'h2D;

  // bytes consumed by one packing group
  function automatic logic [2:0] fmt_grp_bytes(fmt_e f);
    case (f)
      FMT_R10: return 3'd5;
      FMT_R12: return 3'd3;
      FMT_R14: return 3'd7;
      default: return 3'd1;
    endcase
  endfunction

  // pixels produced by one packing group
  function automatic logic [2:0] fmt_grp_pix(fmt_e f);
    case (f)
      FMT_R10: return 3'd4;
      FMT_R12: return 3'd2;
      FMT_R14: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/csid_hdr_decode.sv
module csid_hdr_decode
  import csid_pkg::*;
#(
  parameter int MAXW = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hdr_valid,
  input  logic [5:0] hdr_dt,
  output fmt_e       fmt_now,
  output logic       unsupported
);

  always_comb begin
    fmt_now = FMT_NONE;
    case (hdr_dt)
      DT_RAW10: if (MAXW >= 10) fmt_now = FMT_R10;
      DT_RAW12: if (MAXW >= 12) fmt_now = FMT_R12;
      DT_RAW14: if (MAXW >= 14) fmt_now = FMT_R14;
      default:  fmt_now = FMT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                  unsupported <= 1'b0;
    else if (hdr_valid && fmt_now == FMT_NONE) unsupported <= 1'b1;
  end

  // R8: once raised, the flag holds until reset
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    unsupported |=> unsupported);

endmodule

// File: rtl/csid_unpack.sv
module csid_unpack
  import csid_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAXW  = 14,
  localparam int GPC   = 2,
  localparam int MAXGP = 4,
  localparam int OUTPX = GPC * MAXGP,
  localparam int BB    = 16 + 4 * LANES,
  localparam int BW    = BB * 8,
  localparam int CW    = $clog2(BB + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hdr_valid,
  input  fmt_e                   hdr_fmt,
  input  logic [15:0]            hdr_wc,
  input  logic                   pl_valid,
  input  logic [LANES*8-1:0]     pl_data,
  input  logic                   room,
  output logic [OUTPX*MAXW-1:0]  grp_px,
  output logic [3:0]             grp_n,
  output logic                   grp_last,
  output logic                   pkt_start
);

  fmt_e            fmt_q;
  logic [15:0]     rx_left;
  logic [15:0]     cons_left;
  logic [BW-1:0]   bbuf;
  logic [CW-1:0]   bcnt;

  logic [CW-1:0]   gb, take, nin;
  logic [2:0]      gp;
  logic [1:0]      ng;
  logic [LANES*8-1:0] in_m;
  logic [BW-1:0]   bbuf_n;
  logic [CW-1:0]   bcnt_n;

  always_comb begin
    gb = CW'(fmt_grp_bytes(fmt_q));
    gp = fmt_grp_pix(fmt_q);
    ng = 2'd0;
    if (fmt_q != FMT_NONE && room) begin
      if (bcnt >= CW'(2 * int'(gb)))  ng = 2'd2;
      else if (bcnt >= gb)            ng = 2'd1;
    end
    take = CW'(int'(ng) * int'(gb));
    nin  = '0;
    if (pl_valid)
      nin = (rx_left >= 16'(LANES)) ? CW'(LANES) : CW'(rx_left);
    for (int i = 0; i < LANES; i++)
      in_m[i*8 +: 8] = (CW'(i) < nin) ? pl_data[i*8 +: 8] : 8'h00;
    bbuf_n = (bbuf >> (8 * int'(take))) | (BW'(in_m) << (8 * int'(bcnt - take)));
    bcnt_n = bcnt - take + nin;
  end

  // group extraction: upper bytes first, remainder bytes after them
  always_comb begin
    logic [BW-1:0] gsel;
    logic [23:0]   lsb;
    logic [7:0]    msb;
    logic [15:0]   j16;
    grp_px = '0;
    for (int g = 0; g < GPC; g++) begin
      gsel = bbuf >> (8 * g * int'(gb));
      lsb  = 24'(gsel >> (8 * int'(gp)));
      for (int i = 0; i < MAXGP; i++) begin
        msb = gsel[8*i +: 8];
        case (fmt_q)
          FMT_R10: j16 = {msb, lsb[2*i +: 2], 6'b0};
          FMT_R12: j16 = {msb, lsb[4*i +: 4], 4'b0};
          FMT_R14: j16 = {msb, lsb[6*i +: 6], 2'b0};
          default: j16 = '0;
        endcase
        if (i < int'(gp))
          grp_px[MAXW*(g*int'(gp)+i) +: MAXW] = j16[15 -: MAXW];
      end
    end
    grp_n    = 4'(int'(ng) * int'(gp));
    grp_last = (ng != 2'd0) && (cons_left == 16'(take));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q     <= FMT_NONE;
      rx_left   <= '0;
      cons_left <= '0;
      bbuf      <= '0;
      bcnt      <= '0;
      pkt_start <= 1'b0;
    end else begin
      pkt_start <= 1'b0;
      if (hdr_valid) begin
        fmt_q     <= hdr_fmt;
        rx_left   <= (hdr_fmt != FMT_NONE) ? hdr_wc : 16'd0;
        cons_left <= (hdr_fmt != FMT_NONE) ? hdr_wc : 16'd0;
        bbuf      <= '0;
        bcnt      <= '0;
        pkt_start <= (hdr_fmt != FMT_NONE);
      end else begin
        rx_left   <= rx_left - 16'(nin);
        cons_left <= cons_left - 16'(take);
        bbuf      <= bbuf_n;
        bcnt      <= bcnt_n;
      end
    end
  end

  // R10: the staging buffer never holds more than its size
  a_r10_buf_bound: assert property (@(posedge clk) disable iff (rst)
    bcnt <= CW'(BB));
  // R10: consumption never runs past the packet's byte count
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (rst)
    cons_left >= 16'(take));
  // R4: a new header only arrives once the previous packet is fully consumed
  a_r4_header_gap: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> cons_left == 16'd0);

endmodule

// File: rtl/csid_gearbox.sv
module csid_gearbox #(
  parameter int PPC  = 4,
  parameter int MAXW = 14,
  parameter int INPX = 8,
  localparam int PB  = 2 * INPX,
  localparam int PBW = PB * MAXW,
  localparam int PCW = $clog2(PB + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_start,
  input  logic [INPX*MAXW-1:0]  in_px,
  input  logic [3:0]            in_n,
  input  logic                  in_last,
  output logic                  room,
  output logic                  pix_valid,
  output logic [PPC*MAXW-1:0]   pix_data,
  output logic [PPC-1:0]        pix_keep,
  output logic                  line_start,
  output logic                  line_end
);

  logic [PBW-1:0] pbuf;
  logic [PCW-1:0] pcnt;
  logic           tail_q, first_q;

  logic [PCW-1:0] nout;
  logic           end_now;
  logic [PBW-1:0] pbuf_n;
  logic [PCW-1:0] pcnt_n;
  logic [PPC*MAXW-1:0] data_n;
  logic [PPC-1:0] keep_n;

  assign room = (pcnt <= PCW'(PB - INPX));

  always_comb begin
    if (pcnt >= PCW'(PPC)) nout = PCW'(PPC);
    else if (tail_q)       nout = pcnt;
    else                   nout = '0;
    end_now = tail_q && (pcnt != '0) && (pcnt <= PCW'(PPC));
    pbuf_n  = (pbuf >> (MAXW * int'(nout))) | (PBW'(in_px) << (MAXW * int'(pcnt - nout)));
    pcnt_n  = pcnt - nout + PCW'(in_n);
    for (int j = 0; j < PPC; j++) begin
      keep_n[j]               = (PCW'(j) < nout);
      data_n[j*MAXW +: MAXW]  = keep_n[j] ? pbuf[j*MAXW +: MAXW] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pbuf       <= '0;
      pcnt       <= '0;
      tail_q     <= 1'b0;
      first_q    <= 1'b0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_keep   <= '0;
      line_start <= 1'b0;
      line_end   <= 1'b0;
    end else begin
      pbuf       <= pbuf_n;
      pcnt       <= pcnt_n;
      pix_valid  <= (nout != '0);
      pix_data   <= data_n;
      pix_keep   <= keep_n;
      line_start <= (nout != '0) && first_q;
      line_end   <= end_now;
      if (pkt_start)          first_q <= 1'b1;
      else if (nout != '0)    first_q <= 1'b0;
      if (in_last)            tail_q  <= 1'b1;
      else if (end_now)       tail_q  <= 1'b0;
    end
  end

  // R7: strobes only ride on valid beats
  a_r7_start_on_beat: assert property (@(posedge clk) disable iff (rst)
    line_start |-> pix_valid);
  a_r7_end_on_beat: assert property (@(posedge clk) disable iff (rst)
    line_end |-> pix_valid);
  // R6: occupied lanes are contiguous from lane 0
  a_r6_keep_packed: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (pix_keep != '0) && ((pix_keep & (pix_keep + PPC'(1))) == '0));
  // R6: only the closing beat of a line may be partial
  a_r6_full_mid_line: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !line_end) |-> (&pix_keep));
  // R6: pixel store never overflows
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PCW'(PB));

endmodule

// File: rtl/csi_raw_depack.sv
module csi_raw_depack
  import csid_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PPC   = 4,
  parameter int MAXW  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hdr_valid,
  input  logic [5:0]            hdr_dt,
  input  logic [15:0]           hdr_wc,
  input  logic                  pl_valid,
  input  logic [LANES*8-1:0]    pl_data,
  output logic                  pix_valid,
  output logic [PPC*MAXW-1:0]   pix_data,
  output logic [PPC-1:0]        pix_keep,
  output logic                  line_start,
  output logic                  line_end,
  output logic                  unsupported
);

  localparam int INPX = 8;

  if (!((LANES == 2 && (PPC == 2 || PPC == 4)) ||
        (LANES == 4 && (PPC == 4 || PPC == 8)))) begin : g_bad_geometry
    $error("illegal lane count / pixels-per-clock pairing");
  end
  if (MAXW < 10 || MAXW > 16) begin : g_bad_width
    $error("maximum pixel width must lie in 10..16");
  end

  fmt_e                 fmt_now;
  logic                 room;
  logic [INPX*MAXW-1:0] grp_px;
  logic [3:0]           grp_n;
  logic                 grp_last;
  logic                 pkt_start;

  csid_hdr_decode #(.MAXW(MAXW)) u_hdr (
    .clk        (clk),
    .rst        (rst),
    .hdr_valid  (hdr_valid),
    .hdr_dt     (hdr_dt),
    .fmt_now    (fmt_now),
    .unsupported(unsupported)
  );

  csid_unpack #(.LANES(LANES), .MAXW(MAXW)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .hdr_valid (hdr_valid),
    .hdr_fmt   (fmt_now),
    .hdr_wc    (hdr_wc),
    .pl_valid  (pl_valid),
    .pl_data   (pl_data),
    .room      (room),
    .grp_px    (grp_px),
    .grp_n     (grp_n),
    .grp_last  (grp_last),
    .pkt_start (pkt_start)
  );

  csid_gearbox #(.PPC(PPC), .MAXW(MAXW), .INPX(INPX)) u_gear (
    .clk       (clk),
    .rst       (rst),
    .pkt_start (pkt_start),
    .in_px     (grp_px),
    .in_n      (grp_n),
    .in_last   (grp_last),
    .room      (room),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_keep  (pix_keep),
    .line_start(line_start),
    .line_end  (line_end)
  );

endmodule

// File: tb/csi_raw_depack_test.sv
module csi_raw_depack_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int PPC   = 4;
  localparam int MAXW  = 14;
  localparam int WD_CYCLES = 100000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  hdr_valid = 1'b0;
  logic [5:0]            hdr_dt = '0;
  logic [15:0]           hdr_wc = '0;
  logic                  pl_valid = 1'b0;
  logic [LANES*8-1:0]    pl_data = '0;
  logic                  pix_valid;
  logic [PPC*MAXW-1:0]   pix_data;
  logic [PPC-1:0]        pix_keep;
  logic                  line_start, line_end, unsupported;

  int checks = 0;
  int errors = 0;
  int wr = 0;
  int rd = 0;
  int beats = 0;
  int both_cnt = 0;
  bit done = 1'b0;

  logic [MAXW-1:0] exp_px [2048];
  bit              exp_first [2048];
  bit              exp_last  [2048];
  int              exp_w     [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  csi_raw_depack #(.LANES(LANES), .PPC(PPC), .MAXW(MAXW)) uut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_dt(hdr_dt), .hdr_wc(hdr_wc),
    .pl_valid(pl_valid), .pl_data(pl_data), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_keep(pix_keep), .line_start(line_start), .line_end(line_end),
    .unsupported(unsupported)
  );

  // stimulus table: {data type, pixel count, seed}; formats interleave (R4)
  localparam int NVEC = 10;
  localparam logic [29:0] VEC [NVEC] = '{
    {6'h2B, 8'd16, 16'h1234},
    {6'h2C, 8'd10, 16'h0BEE},
    {6'h2D, 8'd12, 16'h7A11},
    {6'h2C, 8'd2,  16'h00C3},
    {6'h2B, 8'd40, 16'h5A5A},
    {6'h2D, 8'd4,  16'h3141},
    {6'h2C, 8'd64, 16'h2718},
    {6'h2B, 8'd4,  16'hFACE},
    {6'h2D, 8'd28, 16'h1F1F},
    {6'h2C, 8'd6,  16'h0DD0}
  };

  function automatic string req_of(int w);
    if (w == 10) return "R1 R4";
    if (w == 12) return "R2 R4";
    return "R3 R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // output monitor: compares beats with the expected pixel stream
  always @(negedge clk) begin
    if (!rst && pix_valid && !done) begin
      int nk;
      bit mism;
      bit lsb_bad;
      nk = $countones(pix_keep);
      beats++;
      if (line_start && line_end) both_cnt++;
      if (rd + nk > wr) begin
        check(1'b0, "R6", "surplus pixels", rd + nk, wr);
        rd = wr;
      end else begin
        mism = 1'b0;
        lsb_bad = 1'b0;
        for (int j = 0; j < nk; j++) begin
          logic [MAXW-1:0] got;
          got = pix_data[j*MAXW +: MAXW];
          if (got != exp_px[rd+j]) begin
            mism = 1'b1;
            check(1'b0, req_of(exp_w[rd+j]), "pixel", got, exp_px[rd+j]);
          end
          if ((int'(got) & ((1 << (MAXW - exp_w[rd+j])) - 1)) != 0) lsb_bad = 1'b1;
        end
        if (!mism) check(1'b1, req_of(exp_w[rd]), "pixel", 0, 0);
        check(!lsb_bad, "R5", "zero fill below pixel width", lsb_bad, 0);
        check(line_start == exp_first[rd], "R7", "line_start", line_start, exp_first[rd]);
        check(line_end == exp_last[rd+nk-1], "R7", "line_end", line_end, exp_last[rd+nk-1]);
        check(line_end || (pix_keep == '1), "R6", "keep on mid-line beat", pix_keep, 4'hF);
        rd += nk;
      end
    end
  end

  task automatic send_packet(input logic [5:0] dt, input int npix, input logic [15:0] seed);
    int w, k, gpx, nb;
    int unsigned st;
    int pv [256];
    logic [7:0] by [512];
    w   = (dt == 6'h2B) ? 10 : (dt == 6'h2C) ? 12 : 14;
    k   = w - 8;
    gpx = (w == 12) ? 2 : 4;
    st  = {16'h0, seed};
    for (int i = 0; i < npix; i++) begin
      st = st * 32'd1103515245 + 32'd12345;
      pv[i] = int'((st >> 9) & ((32'd1 << w) - 1));
    end
    nb = 0;
    for (int g = 0; g < npix / gpx; g++) begin
      int lw;
      lw = 0;
      for (int i = 0; i < gpx; i++) begin
        by[nb] = 8'(pv[g*gpx+i] >> k);
        nb++;
        lw |= (pv[g*gpx+i] & ((1 << k) - 1)) << (k * i);
      end
      for (int b = 0; b < gpx * k / 8; b++) begin
        by[nb] = 8'(lw >> (8 * b));
        nb++;
      end
    end
    for (int i = 0; i < npix; i++) begin
      exp_px[wr]    = MAXW'(pv[i] << (MAXW - w));
      exp_first[wr] = (i == 0);
      exp_last[wr]  = (i == npix - 1);
      exp_w[wr]     = w;
      wr++;
    end
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dt = dt; hdr_wc = 16'(nb);
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int p = 0; p < nb; p += LANES) begin
      pl_valid = 1'b1;
      for (int l = 0; l < LANES; l++)
        pl_data[l*8 +: 8] = (p + l < nb) ? by[p+l] : (8'hA5 ^ 8'(l));  // R10 junk lanes
      @(negedge clk);
    end
    pl_valid = 1'b0;
    pl_data  = '0;
    repeat (20) @(negedge clk);
  endtask

  task automatic send_junk(input logic [5:0] dt, input int nb);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dt = dt; hdr_wc = 16'(nb);
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int p = 0; p < nb; p += LANES) begin
      pl_valid = 1'b1;
      pl_data  = {LANES{8'h3C}} ^ (LANES*8)'(p);
      @(negedge clk);
    end
    pl_valid = 1'b0;
    pl_data  = '0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    done = 1'b1;
    finish_run();
  end

  initial begin
    int b0;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(pix_valid == 1'b0,   "R9", "pix_valid in reset",   pix_valid, 0);
    check(line_start == 1'b0,  "R9", "line_start in reset",  line_start, 0);
    check(line_end == 1'b0,    "R9", "line_end in reset",    line_end, 0);
    check(unsupported == 1'b0, "R9", "unsupported in reset", unsupported, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(pix_valid == 1'b0 && unsupported == 1'b0, "R9", "idle after reset",
          {pix_valid, unsupported}, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R10 judged per beat by the monitor
    for (int v = 0; v < NVEC; v++)
      send_packet(VEC[v][29:24], int'(VEC[v][23:16]), VEC[v][15:0]);
    check(rd == wr, "R6", "pixels delivered", rd, wr);
    check(both_cnt >= 1, "R7", "beats with both strobes", both_cnt, 1);

    // R10: stray payload with no open packet
    b0 = beats;
    @(negedge clk);
    pl_valid = 1'b1; pl_data = {LANES{8'hEE}};
    @(negedge clk);
    pl_valid = 1'b0; pl_data = '0;
    repeat (20) @(negedge clk);
    check(beats == b0, "R10", "beats after stray payload", beats, b0);

    // R8: unknown types are dropped and flagged
    b0 = beats;
    send_junk(6'h12, 16);
    check(beats == b0, "R8", "beats from unknown type", beats, b0);
    check(unsupported == 1'b1, "R8", "flag after unknown type", unsupported, 1);
    send_junk(6'h2E, 8);
    check(beats == b0, "R8", "beats from 16-bit type", beats, b0);
    send_packet(6'h2B, 8, 16'h4242);
    check(rd == wr, "R8", "valid packet after drop", rd, wr);
    check(unsupported == 1'b1, "R8", "flag sticky over valid packet", unsupported, 1);

    // R9: reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(unsupported == 1'b0, "R9", "flag after reset", unsupported, 0);

    // R4: a format switch straight after reset
    send_packet(6'h2D, 8, 16'h0707);
    send_packet(6'h2C, 4, 16'h0909);
    check(rd == wr, "R4", "pixels after switch", rd, wr);

    done = 1'b1;
    finish_run();
  end

endmodule